// File: doc/BRIEF.md
# Level-Two Interrupt Aggregator

This block collects 32 level-sensitive interrupt request lines and combines them onto a small number of parent interrupt lines. Each request line first crosses a two-stage synchronizer. The synchronized request is then gated by a software-owned enable word. Each parent line is the OR of the gated requests that fall inside a routing mask fixed at build time. A source bit that no routing mask covers is inert: it can still be seen in the status word, but it never raises a parent line.

Software reaches the block through a plain 32-bit register port with an address, a write strobe, write data and combinational read data. The port has no handshake: a write takes effect on the clock edge where the strobe is high, and read data follows the address in the same cycle. The enable word is the only writable state. A source is masked by clearing its enable bit and unmasked by setting it. There is no set or clear alias and no acknowledge register. A pending request goes away only when the source line drops or its enable bit is cleared.

The number of parent lines (1 to 4), the routing masks and the reset value of the enable word are parameters. The defaults are two parent lines with masks 0x00FF00FF and 0x0F00FF00, and an enable reset value of 0x00000101.

Top module: `l2irq_aggregator`

## Requirements
- R1: A read at offset 0x04 returns the status word. Bit i is high exactly when synchronized source i is high and enable bit i is set.
- R2: After reset, the enable word equals the forward-mask parameter (default 0x00000101), every other enable bit is clear, and all parent lines are low.
- R3: A write at offset 0x00 replaces all 32 enable bits on that clock edge. A read at offset 0x00 returns the current enable word.
- R4: A status bit stays high for as long as its source stays high and its enable bit stays set. Reading the status word does not clear it.
- R5: Parent line k (bit k of the irq output) is high exactly when the status word has a set bit inside routing mask k. The defaults are mask 0 = 0x00FF00FF and mask 1 = 0x0F00FF00.
- R6: Source bits outside every routing mask (0xF0000000 by default) never raise any parent line, even when they are enabled and active.
- R7: A write at offset 0x04 leaves the enable word unchanged.
- R8: If a source rises before clock edge n, its parent line (when the source is enabled and routed) goes high after edge n+1 and not before.
- R9: Clearing an enable bit takes effect on the write edge. The parent line falls on that same edge when no other routed status bit is set.
- R10: Reads at any offset other than 0x00 and 0x04 return zero, and writes there leave the enable word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 32 | Level interrupt request lines |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | NUM_PARENT | Parent interrupt lines |

## Verification
The assertions assume that the address, write strobe and write data are stable around the clock edge, and that the source lines change only between edges. The bench drives every input on the falling edge and samples outputs there as well, half a cycle away from the edge where state changes. The timing checks count synchronizer stages from the edge that follows a source change. For that reason each source pattern is held for at least three edges before any result is compared.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;
  localparam int L2_SRC_W   = 32;
  localparam int L2_DATA_W  = 32;
  localparam int L2_MAX_PAR = 4;
  localparam int L2_OFF_ENABLE = 'h00;
  localparam int L2_OFF_STATUS = 'h04;
  localparam int L2_SYNC_STAGES = 2;

  typedef logic [L2_SRC_W-1:0] l2_vec_t;
endpackage

// File: rtl/l2irq_sync.sv
module l2irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/l2irq_regs.sv
module l2irq_regs
  import l2irq_pkg::*;
#(
  parameter int      ADDR_W   = 8,
  parameter l2_vec_t FWD_MASK = 32'h0000_0101
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [L2_DATA_W-1:0] wdata_i,
  input  l2_vec_t              src_sync_i,
  output logic [L2_DATA_W-1:0] rdata_o,
  output l2_vec_t              enable_o,
  output l2_vec_t              status_o
);
  localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(L2_OFF_ENABLE);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(L2_OFF_STATUS);

  l2_vec_t en_q;
  logic    hit_en, hit_st;

  assign hit_en = (addr_i == A_EN);
  assign hit_st = (addr_i == A_ST);

  always_ff @(posedge clk) begin
    if (rst)                  en_q <= FWD_MASK;
    else if (wr_i && hit_en)  en_q <= wdata_i;
  end

  assign status_o = src_sync_i & en_q;
  assign enable_o = en_q;

  always_comb begin
    rdata_o = '0;
    if (hit_en)      rdata_o = en_q;
    else if (hit_st) rdata_o = status_o;
  end

  AST_RESET_FWD: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> en_q == FWD_MASK);                                  // R2
  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_i && hit_en) |=> en_q == $past(wdata_i));                      // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_i && hit_en) |=> $stable(en_q));                              // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(hit_en || hit_st) |-> rdata_o == '0);                            // R10
  AST_STATUS_GATED: assert property (@(posedge clk) disable iff (rst)
    hit_st |-> (rdata_o & ~en_q) == '0);                               // R1
endmodule

// File: rtl/l2irq_route.sv
module l2irq_route
  import l2irq_pkg::*;
#(
  parameter int NUM_PARENT = 2,
  parameter logic [L2_MAX_PAR-1:0][L2_SRC_W-1:0] ROUTE_MASK =
    {32'h0, 32'h0, 32'h0F00_FF00, 32'h00FF_00FF}
) (
  input  l2_vec_t               status_i,
  output logic [NUM_PARENT-1:0] irq_o
);
  generate
    for (genvar k = 0; k < NUM_PARENT; k++) begin : g_par
      assign irq_o[k] = |(status_i & ROUTE_MASK[k]);
    end
  endgenerate
endmodule

// File: rtl/l2irq_aggregator.sv
module l2irq_aggregator
  import l2irq_pkg::*;
#(
  parameter int      ADDR_W     = 8,
  parameter int      NUM_PARENT = 2,
  parameter logic [L2_MAX_PAR-1:0][L2_SRC_W-1:0] ROUTE_MASK =
    {32'h0, 32'h0, 32'h0F00_FF00, 32'h00FF_00FF},
  parameter l2_vec_t FWD_MASK   = 32'h0000_0101
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [L2_SRC_W-1:0]   src_i,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_wr,
  input  logic [L2_DATA_W-1:0]  bus_wdata,
  output logic [L2_DATA_W-1:0]  bus_rdata,
  output logic [NUM_PARENT-1:0] irq_o
);
  l2_vec_t src_sync, enable_w, status_w;

  initial begin
    if (NUM_PARENT < 1 || NUM_PARENT > L2_MAX_PAR)
      $error("NUM_PARENT out of range");
  end

  l2irq_sync #(.WIDTH(L2_SRC_W), .STAGES(L2_SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(src_i), .q_o(src_sync)
  );

  l2irq_regs #(.ADDR_W(ADDR_W), .FWD_MASK(FWD_MASK)) u_regs (
    .clk(clk), .rst(rst), .addr_i(bus_addr), .wr_i(bus_wr),
    .wdata_i(bus_wdata), .src_sync_i(src_sync), .rdata_o(bus_rdata),
    .enable_o(enable_w), .status_o(status_w)
  );

  l2irq_route #(.NUM_PARENT(NUM_PARENT), .ROUTE_MASK(ROUTE_MASK)) u_route (
    .status_i(status_w), .irq_o(irq_o)
  );

  generate
    for (genvar k = 0; k < NUM_PARENT; k++) begin : g_chk
      AST_ROUTE_GATED: assert property (@(posedge clk) disable iff (rst)
        irq_o[k] |-> (ROUTE_MASK[k] & enable_w & src_sync) != '0);      // R6
      AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        (ROUTE_MASK[k] & enable_w) == '0 |-> !irq_o[k]);                // R5
    end
  endgenerate
endmodule

// File: tb/tb_l2irq_aggregator.sv
module tb_l2irq_aggregator;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  l2irq_aggregator dut (
    .clk(clk), .rst(rst), .src_i(src), .bus_addr(addr), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] srcv;
    logic [1:0]  irqx;
    logic [31:0] st;
  } vec_t;

  localparam vec_t VEC [0:7] = '{
    '{32'hFFFF_FFFF, 32'h0000_0001, 2'b01, 32'h0000_0001},
    '{32'hFFFF_FFFF, 32'h0000_0100, 2'b10, 32'h0000_0100},
    '{32'hFFFF_FFFF, 32'hF000_0000, 2'b00, 32'hF000_0000},
    '{32'h0000_FFFF, 32'h0001_0100, 2'b10, 32'h0000_0100},
    '{32'hFFFF_0000, 32'h0001_0100, 2'b01, 32'h0001_0000},
    '{32'h0000_0000, 32'hFFFF_FFFF, 2'b00, 32'h0000_0000},
    '{32'h0F00_0000, 32'h0F00_0000, 2'b10, 32'h0F00_0000},
    '{32'hFFFF_FFFF, 32'h8000_0001, 2'b01, 32'h8000_0001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2: reset state
    bus_read(8'h00, rd); chk("R2 enable reset", rd, 32'h0000_0101);
    chk("R2 irq reset", {30'b0, irq}, 32'h0);
    bus_read(8'h04, rd); chk("R1 status reset", rd, 32'h0);

    // R8: two-edge latency on source 0 (enabled by reset value, routed to parent 0)
    @(negedge clk); src = 32'h0000_0001;
    @(negedge clk); chk("R8 after one edge", {30'b0, irq}, 32'h0);
    @(negedge clk); chk("R8 after two edges", {30'b0, irq}, 32'h1);

    // R9: clearing enable drops the line on the write edge
    @(negedge clk); addr = 8'h00; wdata = 32'h0; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    chk("R9 drop on write edge", {30'b0, irq}, 32'h0);
    src = '0;

    // table walk: R1 R3 R5 R6
    for (int i = 0; i < 8; i++) begin
      bus_write(8'h00, VEC[i].en);
      src = VEC[i].srcv;
      settle();
      bus_read(8'h00, rd); chk("R3 enable readback", rd, VEC[i].en);
      bus_read(8'h04, rd); chk("R1 status", rd, VEC[i].st);
      chk("R5 R6 parent lines", {30'b0, irq}, {30'b0, VEC[i].irqx});
    end

    // R4: level held, reads do not clear
    bus_write(8'h00, 32'h0000_0100);
    src = 32'h0000_0100;
    settle();
    bus_read(8'h04, rd);
    bus_read(8'h04, rd);
    repeat (4) @(negedge clk);
    bus_read(8'h04, rd); chk("R4 status held", rd, 32'h0000_0100);
    chk("R4 irq held", {30'b0, irq}, 32'h2);

    // R7: status offset write ignored
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h00, rd); chk("R7 enable unchanged", rd, 32'h0000_0100);

    // R10: other offsets
    bus_write(8'h08, 32'hFFFF_FFFF);
    bus_read(8'h00, rd); chk("R10 enable unchanged", rd, 32'h0000_0100);
    bus_read(8'h08, rd); chk("R10 read zero", rd, 32'h0);
    bus_read(8'h01, rd); chk("R10 read zero near", rd, 32'h0);

    // R6: unused bits alone never raise a line
    bus_write(8'h00, 32'hF000_0000);
    src = 32'hF000_0000;
    settle();
    chk("R6 unused bits quiet", {30'b0, irq}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule